// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the host-visible register file and command sequencer of one ATA drive channel. A host reads and writes eight byte-wide locations on a simple register-port bus. Those locations hold the parameter bytes of a command (sector count, three address bytes and the device byte), the error byte, and the command/status byte. Writing the command location starts a command. The controller then keeps the status bits in the order that command requires. It raises an interrupt at each point where the host has to act, and it lowers the interrupt only when the host reads status.

Two commands are executed. IDENTIFY (0xEC) streams a fixed number of 16-bit words out of the data location. The words are fetched one at a time from an external read-only identify table, through an address/data port. FLUSH CACHE (0xE7) holds a request to a backing-storage stub until the stub answers with either completion or rejection. Every other opcode is rejected at once, and so is any command issued while the device byte selects the second device.

The sequencer has three states. CS_IDLE waits for a command. CS_DATA_IN is the word-transfer phase of IDENTIFY. CS_FLUSH_WAIT is the busy phase of FLUSH CACHE. The transitions are:
- idle→data_in on an accepted IDENTIFY.
- idle→flush_wait on an accepted FLUSH CACHE.
- idle→idle on a rejected opcode.
- data_in→idle on the read of the last word.
- data_in→data_in or data_in→flush_wait when a new command is accepted mid-transfer.
- flush_wait→idle on storage completion or rejection.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, status (offset 7) reads 0x40, the error byte (offset 1) reads 0x00, the interrupt is low, the storage request is low and the identify address is 0.
- R2: Offsets 2 to 6 (count, address low/mid/high, device) read back the last byte written there. Writing offset 1 (feature) does not change what offset 1 reads (error byte).
- R3: An accepted IDENTIFY (0xEC at offset 7, device byte bit 4 clear) raises the interrupt, and from the next cycle status reads 0x48 with identify address 0. Each read of offset 0 returns the table word at the current address and then advances the address. After the read of word ID_WORDS-1, status reads 0x40.
- R4: An accepted FLUSH CACHE (0xE7) makes status read 0xC0 and holds the storage request high until the storage stub answers. Completion makes status read 0x40 and raises the interrupt.
- R5: A storage rejection during FLUSH CACHE makes status read 0x41, makes the error byte read 0x04 (abort), and raises the interrupt.
- R6: Any opcode other than 0xEC and 0xE7 completes in one cycle. Status then reads 0x41, the error byte reads 0x04, and the interrupt is raised.
- R7: Any command written while device byte bit 4 is set is rejected as in R6.
- R8: A read of offset 7 deasserts the interrupt from the next cycle on. Reads of other offsets leave it unchanged.
- R9: A command write while BSY (status bit 7) is set is ignored: the flush in progress continues and ends as in R4.
- R10: An accepted IDENTIFY or FLUSH CACHE clears ERR (status bit 0) and the error byte.
- R11: A read of offset 0 outside the identify phase returns 0x0000 and has no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe; read side effects take place on the clock edge |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request line |
| store_req | output | 1 | Flush request to the storage stub, held while busy |
| store_done | input | 1 | Storage completed the flush |
| store_abort | input | 1 | Storage rejected the flush |
| rom_addr | output | 8 | Identify table word address |
| rom_data | input | 16 | Identify table word at rom_addr |

## Verification
The bench reads all ID_WORDS words of an identify transfer and checks the final word closely. A counter that is off by one would leave DRQ set after the last word, or drop it one word early. It also issues commands during a flush. A design that accepts them would leave BSY early or go into the data phase. It checks that the interrupt survives reads of non-status offsets, because clearing on any read loses the event. It checks that a good command after a rejected one clears the stale abort code. Random parameter bytes and random illegal opcodes cover the register decode and the reject path.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam logic [2:0] OFS_DATA    = 3'd0;
    localparam logic [2:0] OFS_ERRFEAT = 3'd1;
    localparam logic [2:0] OFS_CMDSTAT = 3'd7;

    localparam logic [7:0] ST_BSY  = 8'h80;
    localparam logic [7:0] ST_DRDY = 8'h40;
    localparam logic [7:0] ST_DRQ  = 8'h08;
    localparam logic [7:0] ST_ERR  = 8'h01;
    localparam logic [7:0] ER_ABRT = 8'h04;

    localparam int unsigned DEV_SEL_BIT = 4;

    localparam logic [7:0] OP_IDENTIFY = 8'hEC;
    localparam logic [7:0] OP_FLUSH    = 8'hE7;

    typedef enum logic [1:0] {
        CS_IDLE,
        CS_DATA_IN,
        CS_FLUSH_WAIT
    } cmd_state_e;

endpackage

// File: rtl/ata_tf_shadow.sv
module ata_tf_shadow #(
    parameter int FIRST = 2,
    parameter int COUNT = 5,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rd_byte,
    output logic [7:0]    device_q
);
    localparam int DEV_IDX = COUNT - 1;

    logic [7:0] regs_q [COUNT];

    for (genvar g = 0; g < COUNT; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && addr == AW'(FIRST + g))
                regs_q[g] <= wdata;
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < COUNT; i++) begin
            if (addr == AW'(FIRST + i))
                rd_byte = regs_q[i];
        end
    end

    assign device_q = regs_q[DEV_IDX];

endmodule

// File: rtl/ata_tf_cmd_fsm.sv
module ata_tf_cmd_fsm
    import ata_tf_pkg::*;
#(
    parameter int ID_WORDS = 256,
    localparam int IW = $clog2(ID_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_code,
    input  logic          dev_one,
    input  logic          data_rd,
    input  logic          stat_rd,
    input  logic          store_done,
    input  logic          store_abort,
    output logic          busy,
    output logic          drq,
    output logic          err_flag,
    output logic [7:0]    err_code,
    output logic          irq,
    output logic          store_req,
    output logic [IW-1:0] word_idx
);
    cmd_state_e state_q, state_d;

    logic          accept, start_id, start_flush, reject;
    logic          last_word, flush_end;
    logic          set_irq, set_err, clr_err;
    logic          err_q, irq_q;
    logic [7:0]    code_q;
    logic [IW-1:0] idx_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    // command decode and next state
    always_comb begin
        accept      = cmd_wr && (state_q != CS_FLUSH_WAIT);
        start_id    = 1'b0;
        start_flush = 1'b0;
        reject      = 1'b0;
        if (accept) begin
            if (dev_one)                   reject      = 1'b1;
            else if (cmd_code == OP_IDENTIFY) start_id = 1'b1;
            else if (cmd_code == OP_FLUSH)    start_flush = 1'b1;
            else                           reject      = 1'b1;
        end
        last_word = (idx_q == IW'(ID_WORDS - 1));
        flush_end = (state_q == CS_FLUSH_WAIT) && (store_done || store_abort);

        state_d = state_q;
        unique case (state_q)
            CS_IDLE, CS_DATA_IN: begin
                if (start_id)         state_d = CS_DATA_IN;
                else if (start_flush) state_d = CS_FLUSH_WAIT;
                else if (reject)      state_d = CS_IDLE;
                else if (state_q == CS_DATA_IN && data_rd && last_word)
                                      state_d = CS_IDLE;
            end
            CS_FLUSH_WAIT: begin
                if (flush_end)        state_d = CS_IDLE;
            end
            default:                  state_d = CS_IDLE;
        endcase

        set_irq = start_id || reject || flush_end;
        set_err = reject || ((state_q == CS_FLUSH_WAIT) && store_abort);
        clr_err = start_id || start_flush;
    end

    // datapath registers: word index, error, interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            err_q  <= 1'b0;
            code_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (start_id)
                idx_q <= '0;
            else if (state_q == CS_DATA_IN && data_rd)
                idx_q <= last_word ? '0 : idx_q + 1'b1;

            if (set_err) begin
                err_q  <= 1'b1;
                code_q <= ER_ABRT;
            end else if (clr_err) begin
                err_q  <= 1'b0;
                code_q <= '0;
            end

            if (set_irq)      irq_q <= 1'b1;
            else if (stat_rd) irq_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q == CS_FLUSH_WAIT);
        drq       = (state_q == CS_DATA_IN);
        store_req = (state_q == CS_FLUSH_WAIT);
        err_flag  = err_q;
        err_code  = code_q;
        irq       = irq_q;
        word_idx  = idx_q;
    end

    assert_irq_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !cmd_wr && !(busy && (store_done || store_abort))) |=> !irq);

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !store_done && !store_abort) |=> busy);

    assert_store_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(store_req) |-> $past(store_done || store_abort));

    assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(cmd_wr || store_abort));

    assert_data_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> (word_idx == '0) && irq);

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int ID_WORDS = 256,
    localparam int IW = $clog2(ID_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    bus_addr,
    input  logic          bus_wr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_rd,
    output logic [15:0]   bus_rdata,
    output logic          irq,
    output logic          store_req,
    input  logic          store_done,
    input  logic          store_abort,
    output logic [IW-1:0] rom_addr,
    input  logic [15:0]   rom_data
);
    logic       busy, drq, err_flag;
    logic [7:0] err_code, shadow_byte, device_q, status;
    logic       cmd_wr, data_rd, stat_rd;

    assign cmd_wr  = bus_wr && (bus_addr == OFS_CMDSTAT);
    assign data_rd = bus_rd && (bus_addr == OFS_DATA);
    assign stat_rd = bus_rd && (bus_addr == OFS_CMDSTAT);

    ata_tf_shadow #(.FIRST(2), .COUNT(5), .AW(3)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rd_byte  (shadow_byte),
        .device_q (device_q)
    );

    ata_tf_cmd_fsm #(.ID_WORDS(ID_WORDS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_code    (bus_wdata),
        .dev_one     (device_q[DEV_SEL_BIT]),
        .data_rd     (data_rd),
        .stat_rd     (stat_rd),
        .store_done  (store_done),
        .store_abort (store_abort),
        .busy        (busy),
        .drq         (drq),
        .err_flag    (err_flag),
        .err_code    (err_code),
        .irq         (irq),
        .store_req   (store_req),
        .word_idx    (rom_addr)
    );

    always_comb begin
        status = ST_DRDY;
        if (busy)     status = status | ST_BSY;
        if (drq)      status = status | ST_DRQ;
        if (err_flag) status = status | ST_ERR;
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DATA:    bus_rdata = drq ? rom_data : 16'h0000;
            OFS_ERRFEAT: bus_rdata = {8'h00, err_code};
            OFS_CMDSTAT: bus_rdata = {8'h00, status};
            default:     bus_rdata = {8'h00, shadow_byte};
        endcase
    end

endmodule

// File: tb/tb_ata_taskfile_ctrl.sv
`timescale 1ns/1ps
module tb_ata_taskfile_ctrl;
    localparam int NW = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        irq, store_req;
    logic        store_done = 1'b0, store_abort = 1'b0;
    logic [7:0]  rom_addr;
    logic [15:0] rom_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] rom_fn(input logic [7:0] a);
        return ({a, ~a} ^ 16'h5A3C) + {8'h00, a};
    endfunction

    assign rom_data = rom_fn(rom_addr);

    ata_taskfile_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq(irq), .store_req(store_req), .store_done(store_done),
        .store_abort(store_abort), .rom_addr(rom_addr), .rom_data(rom_data)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_store(input bit abort_it);
        @(negedge clk);
        if (abort_it) store_abort = 1'b1; else store_done = 1'b1;
        @(negedge clk);
        store_abort = 1'b0; store_done = 1'b0;
    endtask

    function automatic logic [7:0] exp_reject_status();
        return 8'h41;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(3'd7, v); chk("R1 status", v, 16'h0040);
        peek(3'd1, v); chk("R1 error", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 store_req", {15'd0, store_req}, 16'd0);
        chk("R1 rom_addr", {8'd0, rom_addr}, 16'd0);

        // R11 data read while idle
        rd(3'd0, v); chk("R11 data idle", v, 16'h0000);
        peek(3'd7, v); chk("R11 status unchanged", v, 16'h0040);

        // R2 random shadow register readback
        for (int k = 0; k < 40; k++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'(2 + ($urandom % 5));
            d = 8'($urandom);
            wr(a, d);
            rd(a, v); chk("R2 readback", v, {8'h00, d});
        end
        wr(3'd1, 8'hFF);
        rd(3'd1, v); chk("R2 feature not error", v, 16'h0000);

        // R6 random illegal opcodes, device 0
        wr(3'd6, 8'h40);
        for (int k = 0; k < 20; k++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if (op == 8'hEC || op == 8'hE7) op = 8'h00;
            wr(3'd7, op);
            peek(3'd7, v); chk("R6 reject status", v, {8'h00, exp_reject_status()});
            peek(3'd1, v); chk("R6 abort code", v, 16'h0004);
            chk("R6 irq", {15'd0, irq}, 16'd1);
            rd(3'd1, v);
            chk("R8 irq kept after error read", {15'd0, irq}, 16'd1);
            rd(3'd7, v);
            chk("R8 irq cleared", {15'd0, irq}, 16'd0);
        end

        // R10 good command after reject clears error; R4 flush
        wr(3'd7, 8'hE7);
        peek(3'd7, v); chk("R4 busy status", v, 16'h00C0);
        peek(3'd1, v); chk("R10 error cleared", v, 16'h0000);
        chk("R4 store_req", {15'd0, store_req}, 16'd1);
        // R9 commands ignored while busy
        wr(3'd7, 8'hEC);
        wr(3'd7, 8'h55);
        peek(3'd7, v); chk("R9 still busy", v, 16'h00C0);
        chk("R9 irq quiet", {15'd0, irq}, 16'd0);
        repeat (5) @(negedge clk);
        chk("R4 request held", {15'd0, store_req}, 16'd1);
        pulse_store(1'b0);
        peek(3'd7, v); chk("R4 done status", v, 16'h0040);
        chk("R4 irq", {15'd0, irq}, 16'd1);
        chk("R4 release", {15'd0, store_req}, 16'd0);
        rd(3'd7, v); chk("R8 status read value", v, 16'h0040);
        chk("R8 irq cleared", {15'd0, irq}, 16'd0);

        // R5 storage rejection
        wr(3'd7, 8'hE7);
        pulse_store(1'b1);
        peek(3'd7, v); chk("R5 status", v, 16'h0041);
        peek(3'd1, v); chk("R5 abort code", v, 16'h0004);
        chk("R5 irq", {15'd0, irq}, 16'd1);
        rd(3'd7, v);

        // R7 device 1 selected
        wr(3'd6, 8'h50);
        rd(3'd6, v); chk("R7 device readback", v, 16'h0050);
        wr(3'd7, 8'hEC);
        peek(3'd7, v); chk("R7 reject status", v, 16'h0041);
        peek(3'd1, v); chk("R7 abort code", v, 16'h0004);
        rd(3'd7, v);

        // R3 identify on device 0
        wr(3'd6, 8'h40);
        wr(3'd7, 8'hEC);
        peek(3'd7, v); chk("R3 drq status", v, 16'h0048);
        peek(3'd1, v); chk("R10 error cleared by identify", v, 16'h0000);
        chk("R3 irq", {15'd0, irq}, 16'd1);
        rd(3'd7, v);
        chk("R8 irq cleared in data phase", {15'd0, irq}, 16'd0);
        for (int i = 0; i < NW; i++) begin
            rd(3'd0, v); chk("R3 identify word", v, rom_fn(8'(i)));
            if (i == NW - 2) begin
                peek(3'd7, v); chk("R3 drq before last", v, 16'h0048);
            end
        end
        peek(3'd7, v); chk("R3 end status", v, 16'h0040);
        rd(3'd6, v); chk("R3 device bit 0", v & 16'h0010, 16'h0000);
        rd(3'd0, v); chk("R11 data after end", v, 16'h0000);

        finished = 1;
        summary();
    end
endmodule